// File: doc/BRIEF.md
# Transmit Descriptor Ring Pointer Manager

This block keeps the pointer state for a set of transmit descriptor rings that live in host memory, four rings by default. Each ring has a 64-bit base address, a byte length, a head index and a tail index. A single-cycle register port lets software write these values and read them back. Software moves a ring's tail forward when it has placed new descriptors in memory. The hardware owns every slot from head up to, but not including, tail.

A ring has work when its head and tail differ. The block picks one such ring and raises a fetch request that carries the queue number and the byte address of the descriptor at head. Each descriptor is 16 bytes. The request stays up until the descriptor engine answers with a done pulse tagged with the same queue number. The block then moves that ring's head forward by one, wrapping to zero at the end of the ring. The head that software reads is this internal head. It counts a descriptor as finished once the engine takes it, even if its write-back has not yet reached memory.

Register address is `{queue, field}`, where the upper bits select the queue and the low three bits select the field. Field codes: 0 = base low word, 1 = base high word, 2 = length, 3 = head (read-only), 4 = tail, and 5 to 7 are reserved.

Top module: `txr_ring_ptr_mgr`

## Requirements
- R1: Base is written as two 32-bit words, the low word at field 0 and the high word at field 1. Bits [3:0] of the low word are dropped and read back as zero. All other bits read back as written.
- R2: Length (field 2) holds bits [17:7] of the written value with the default 13-bit index. Bits [6:0] and bits above 17 read back as zero.
- R3: Tail (field 4) reads back the low 13 bits written to it. Head (field 3) cannot be written: a write to it leaves the value read back unchanged. Reserved fields 5 to 7 read as zero.
- R4: A write to field 0, 1 or 2 of a queue sets that queue's head and tail to zero.
- R5: A queue has work only when its head differs from its tail and its length is not zero. No fetch request is raised for a queue without work.
- R6: A fetch request carries the address base + head × 16 of the granted queue. The request, its queue number and its address stay unchanged until the matching done pulse arrives.
- R7: A done pulse whose queue tag matches the outstanding request advances that queue's head by one. When the new value would equal length ÷ 16, head becomes zero instead. A done pulse with any other tag, or with no request outstanding, changes nothing.
- R8: At most one request is outstanding at a time. The request drops in the cycle after its done pulse.
- R9: When several queues have work, grants rotate round-robin, starting from the queue after the one granted last. Queue 0 is first after reset.
- R10: After reset every field of every queue reads zero and no fetch request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: {queue[1:0], field[2:0]} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| fetch_valid | output | 1 | A descriptor fetch is outstanding |
| fetch_qid | output | 2 | Queue of the outstanding fetch |
| fetch_addr | output | 64 | Byte address of the descriptor to fetch |
| fetch_done | input | 1 | Completion pulse from the descriptor engine |
| done_qid | input | 2 | Queue tag of the completion pulse |

## Verification
The fetch path is tried with three patterns. The first has a single queue whose tail is a few slots ahead of head, which isolates the address arithmetic and the single-step head advance. The second moves tail behind head so that head must pass the last slot, which tells a correct wrap point from an off-by-one length divide. The third gives three queues work at once; the order in which they are granted shows whether the arbiter rotates from the last winner or always favours a fixed queue. Around these patterns, completions with a wrong tag, writes to head, and tail moves on a zero-length ring each show that the block ignores what it should, and writes to base or length show that they clear the pointers.

// File: rtl/txr_pkg.sv
package txr_pkg;
   // Register field codes (low three bits of the register address)
   typedef enum logic [2:0] {
      FLD_BASE_LO = 3'd0,
      FLD_BASE_HI = 3'd1,
      FLD_LEN     = 3'd2,
      FLD_HEAD    = 3'd3,
      FLD_TAIL    = 3'd4
   } txr_fld_e;

   localparam int FLD_W     = 3;
   localparam int DESC_LSB  = 4;   // 16-byte descriptors, 16-byte base alignment
   localparam int LEN_LSB   = 7;   // length granularity of 128 bytes
   localparam int ADDR_W    = 64;
endpackage

// File: rtl/txr_queue_regs.sv
module txr_queue_regs
   import txr_pkg::*;
#(
   parameter int PTR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FLD_W-1:0]  fld,
   input  logic [31:0]       wdata,
   input  logic              adv,
   output logic [ADDR_W-1:0] base,
   output logic [31:0]       len_rd,
   output logic [PTR_W-1:0]  head,
   output logic [PTR_W-1:0]  tail,
   output logic              pending
);
   localparam int LEN_W = PTR_W + DESC_LSB + 1;
   localparam int CNT_W = PTR_W + 1;

   if (LEN_W > 32 || LEN_W <= LEN_LSB) begin : g_bad_ptr_w
      $error("txr_queue_regs: PTR_W out of range");
   end

   logic [ADDR_W-1:DESC_LSB] base_q;
   logic [LEN_W-1:LEN_LSB]   len_q;
   logic [LEN_W-1:0]         len_full;
   logic [CNT_W-1:0]         slots;
   logic [CNT_W-1:0]         head_inc;
   logic [PTR_W-1:0]         head_nx;
   logic                     clr;

   assign len_full = {len_q, {LEN_LSB{1'b0}}};
   assign slots    = len_full[LEN_W-1:DESC_LSB];
   assign head_inc = {1'b0, head} + CNT_W'(1);
   assign head_nx  = (head_inc == slots) ? '0 : head_inc[PTR_W-1:0];
   assign clr      = wr_en && (fld == FLD_BASE_LO || fld == FLD_BASE_HI || fld == FLD_LEN);

   assign base    = {base_q, {DESC_LSB{1'b0}}};
   assign len_rd  = 32'(len_full);
   assign pending = (head != tail) && (len_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
         head   <= '0;
         tail   <= '0;
      end else begin
         if (wr_en) begin
            case (fld)
               FLD_BASE_LO: base_q[31:DESC_LSB]     <= wdata[31:DESC_LSB];
               FLD_BASE_HI: base_q[ADDR_W-1:32]     <= wdata;
               FLD_LEN:     len_q                   <= wdata[LEN_W-1:LEN_LSB];
               FLD_TAIL:    tail                    <= wdata[PTR_W-1:0];
               default:     ;
            endcase
         end
         if (clr) begin
            head <= '0;
            tail <= '0;
         end else if (adv) begin
            head <= head_nx;
         end
      end
   end

   // R7
   head_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q != '0) |-> ({1'b0, head} < slots));

   // R3
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(head));

   // R4
   clear_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (head == '0 && tail == '0));
endmodule

// File: rtl/txr_arb.sv
module txr_arb #(
   parameter int NQ     = 4,
   parameter bit RR     = 1'b1,
   localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NQ-1:0] req,
   input  logic          take,
   output logic [NQ-1:0] grant,
   output logic [QW-1:0] gnt_idx,
   output logic          any
);
   assign any = |req;

   if (RR) begin : g_rr
      logic [QW-1:0] last_q;

      always_comb begin
         grant   = '0;
         gnt_idx = '0;
         for (int i = 1; i <= NQ; i++) begin
            if (req[(int'(last_q) + i) % NQ] && grant == '0) begin
               grant[(int'(last_q) + i) % NQ] = 1'b1;
               gnt_idx = QW'((int'(last_q) + i) % NQ);
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    last_q <= QW'(NQ - 1);
         else if (take) last_q <= gnt_idx;
      end
   end else begin : g_fixed
      always_comb begin
         grant   = '0;
         gnt_idx = '0;
         for (int i = 0; i < NQ; i++) begin
            if (req[i] && grant == '0) begin
               grant[i] = 1'b1;
               gnt_idx  = QW'(i);
            end
         end
      end
   end

   // R9
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R5
   grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
endmodule

// File: rtl/txr_ring_ptr_mgr.sv
module txr_ring_ptr_mgr
   import txr_pkg::*;
#(
   parameter int NQ      = 4,
   parameter int PTR_W   = 13,
   parameter bit RR_ARB  = 1'b1,
   localparam int QW     = (NQ > 1) ? $clog2(NQ) : 1,
   localparam int AW     = QW + FLD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [AW-1:0]     reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              fetch_valid,
   output logic [QW-1:0]     fetch_qid,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_done,
   input  logic [QW-1:0]     done_qid
);
   if (NQ < 2 || (NQ & (NQ - 1)) != 0) begin : g_bad_nq
      $error("txr_ring_ptr_mgr: NQ must be a power of two, at least 2");
   end

   logic [ADDR_W-1:0] base_a [NQ];
   logic [31:0]       len_a  [NQ];
   logic [PTR_W-1:0]  head_a [NQ];
   logic [PTR_W-1:0]  tail_a [NQ];
   logic [ADDR_W-1:0] desc_a [NQ];
   logic [NQ-1:0]     pend_v;
   logic [NQ-1:0]     adv_v;
   logic [NQ-1:0]     grant;
   logic [QW-1:0]     gnt_idx;
   logic              any_pend;
   logic              start;
   logic              finish;
   logic [QW-1:0]     sel_q;
   logic [FLD_W-1:0]  sel_f;

   assign sel_q  = reg_addr[AW-1:FLD_W];
   assign sel_f  = reg_addr[FLD_W-1:0];
   assign start  = !fetch_valid && any_pend;
   assign finish = fetch_valid && fetch_done && (done_qid == fetch_qid);

   for (genvar q = 0; q < NQ; q++) begin : g_queue
      assign adv_v[q]  = finish && (fetch_qid == QW'(q));
      assign desc_a[q] = base_a[q] + (ADDR_W'(head_a[q]) << DESC_LSB);

      txr_queue_regs #(.PTR_W(PTR_W)) regs_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_wr_en && (sel_q == QW'(q))),
         .fld     (sel_f),
         .wdata   (reg_wdata),
         .adv     (adv_v[q]),
         .base    (base_a[q]),
         .len_rd  (len_a[q]),
         .head    (head_a[q]),
         .tail    (tail_a[q]),
         .pending (pend_v[q])
      );
   end

   txr_arb #(.NQ(NQ), .RR(RR_ARB)) arb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (pend_v),
      .take    (start),
      .grant   (grant),
      .gnt_idx (gnt_idx),
      .any     (any_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_valid <= 1'b0;
         fetch_qid   <= '0;
         fetch_addr  <= '0;
      end else if (start) begin
         fetch_valid <= 1'b1;
         fetch_qid   <= gnt_idx;
         fetch_addr  <= desc_a[gnt_idx];
      end else if (finish) begin
         fetch_valid <= 1'b0;
      end
   end

   always_comb begin
      case (sel_f)
         FLD_BASE_LO: reg_rdata = base_a[sel_q][31:0];
         FLD_BASE_HI: reg_rdata = base_a[sel_q][ADDR_W-1:32];
         FLD_LEN:     reg_rdata = len_a[sel_q];
         FLD_HEAD:    reg_rdata = 32'(head_a[sel_q]);
         FLD_TAIL:    reg_rdata = 32'(tail_a[sel_q]);
         default:     reg_rdata = '0;
      endcase
   end

   // R6
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !finish) |=> (fetch_valid && $stable(fetch_qid) && $stable(fetch_addr)));

   // R8
   fetch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !fetch_valid);

   // R7
   one_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(adv_v));

   // R5
   start_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (grant != '0));
endmodule

// File: tb/txr_ring_ptr_mgr_tb_top.sv
`timescale 1ns/1ps
module txr_ring_ptr_mgr_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fetch_valid;
   logic [1:0]  fetch_qid;
   logic [63:0] fetch_addr;
   logic        fetch_done = 1'b0;
   logic [1:0]  done_qid = '0;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [63:0] B0 = 64'h0000_0001_0000_1000;
   localparam logic [63:0] B1 = 64'h0000_0000_0000_2000;
   localparam logic [63:0] B2 = 64'h1234_5678_0000_3000;

   always #5 clk = ~clk;

   txr_ring_ptr_mgr dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
      .fetch_qid(fetch_qid), .fetch_addr(fetch_addr), .fetch_done(fetch_done),
      .done_qid(done_qid)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int q, input int f, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = 5'((q << 3) | f);
      reg_wdata = d;
      reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input int q, input int f, output logic [31:0] d);
      reg_addr = 5'((q << 3) | f);
      #1;
      d = reg_rdata;
   endtask

   task automatic expect_reg(input string req, input int q, input int f, input logic [31:0] exp);
      logic [31:0] v;
      rd(q, f, v);
      chk(req, 64'(v), 64'(exp));
   endtask

   task automatic expect_idle(input string req);
      logic seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (fetch_valid) seen = 1'b1;
      end
      chk(req, 64'(seen), 64'd0);
   endtask

   task automatic serve(input string req, input logic [1:0] q, input logic [63:0] a);
      bit got = 1'b0;
      for (int i = 0; i < 20 && !got; i++) begin
         @(negedge clk);
         if (fetch_valid) got = 1'b1;
      end
      chk({req, " request raised"}, 64'(got), 64'd1);
      chk({req, " queue"}, 64'(fetch_qid), 64'(q));
      chk({req, " address"}, fetch_addr, a);
      fetch_done = 1'b1;
      done_qid   = q;
      @(negedge clk);
      fetch_done = 1'b0;
      chk("R8 request drops after done", 64'(fetch_valid), 64'd0);
   endtask

   task automatic t_reset();
      for (int q = 0; q < 4; q++)
         for (int f = 0; f < 8; f++)
            expect_reg("R10 reset value", q, f, 32'h0);
      chk("R10 no request after reset", 64'(fetch_valid), 64'd0);
   endtask

   task automatic t_fields();
      wr(2, 0, 32'hDEAD_BEEF);
      expect_reg("R1 base low drops bits 3:0", 2, 0, 32'hDEAD_BEE0);
      wr(2, 1, 32'h1234_5678);
      expect_reg("R1 base high word", 2, 1, 32'h1234_5678);
      wr(2, 2, 32'hFFFF_FFFF);
      expect_reg("R2 length keeps bits 17:7", 2, 2, 32'h0003_FF80);
      wr(2, 3, 32'h0000_0005);
      expect_reg("R3 head write ignored", 2, 3, 32'h0);
      expect_reg("R3 reserved field reads zero", 2, 6, 32'h0);
      expect_idle("R5 no fetch when head equals tail");
   endtask

   task automatic t_zero_len();
      wr(3, 4, 32'h0000_0009);
      expect_reg("R3 tail read back", 3, 4, 32'h9);
      expect_idle("R5 no fetch on zero-length ring");
      wr(3, 1, 32'h0000_0000);
      expect_reg("R4 base write clears tail", 3, 4, 32'h0);
   endtask

   task automatic t_single();
      logic [31:0] v;
      wr(0, 1, 32'h0000_0001);
      wr(0, 0, 32'h0000_100F);
      wr(0, 2, 32'h0000_0080);
      wr(0, 4, 32'h0000_0003);
      repeat (3) @(negedge clk);
      fetch_done = 1'b1;
      done_qid   = 2'd1;
      @(negedge clk);
      fetch_done = 1'b0;
      @(negedge clk);
      chk("R7 wrong-tag done keeps request", 64'(fetch_valid), 64'd1);
      rd(0, 3, v);
      chk("R7 wrong-tag done keeps head", 64'(v), 64'd0);
      serve("R6 single q0 head0", 2'd0, B0);
      serve("R6 single q0 head1", 2'd0, B0 + 64'd16);
      serve("R6 single q0 head2", 2'd0, B0 + 64'd32);
      expect_reg("R7 head after three done", 0, 3, 32'd3);
      expect_idle("R5 ring drained");
   endtask

   task automatic t_wrap();
      wr(0, 4, 32'h0000_0001);
      for (int h = 3; h < 8; h++)
         serve("R7 wrap walk", 2'd0, B0 + 64'(h * 16));
      serve("R7 slot after wrap", 2'd0, B0);
      expect_reg("R7 head wrapped to 1", 0, 3, 32'd1);
      expect_idle("R5 drained after wrap");
   endtask

   task automatic t_rr();
      wr(1, 0, 32'h0000_2000);
      wr(1, 2, 32'h0000_0080);
      wr(1, 4, 32'h0000_0001);
      wr(2, 0, 32'h0000_3000);
      wr(2, 4, 32'h0000_0001);
      wr(0, 4, 32'h0000_0003);
      serve("R9 first grant q1", 2'd1, B1);
      serve("R9 next grant q2", 2'd2, B2);
      serve("R9 then q0", 2'd0, B0 + 64'd16);
      serve("R9 q0 again", 2'd0, B0 + 64'd32);
      expect_idle("R5 all rings drained");
   endtask

   task automatic t_len_clear();
      wr(0, 2, 32'h0000_0100);
      expect_reg("R4 length write clears head", 0, 3, 32'h0);
      expect_reg("R4 length write clears tail", 0, 4, 32'h0);
      expect_reg("R2 new length", 0, 2, 32'h0000_0100);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_zero_len();
      t_single();
      t_wrap();
      t_rr();
      t_len_clear();
      summary();
   end
endmodule